// File: doc/BRIEF.md
# Accumulator-Side Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit meant to sit next to an accumulator register. It takes the accumulator value, a second data operand and a 3-bit operation code. It returns a result word and a carry bit. The carry and the result come from one (W+1)-bit value. The carry is its top bit, so any overflow out of the adder lands in the carry and not in the result.

Eight operations are provided: constant zero, increment of the accumulator, addition of both operands, pass-through of the data operand, bitwise inversion of the accumulator, and bitwise AND, OR and XOR of the two operands. The increment and the addition share one adder. The caller feeds the result back into its accumulator register, which lies outside this block. The result width is a parameter with a default of 8 bits.

An operation code that does not resolve to a defined value, for example one carrying unknown bits, drives every output bit to unknown in four-state simulation.

Top module: `accu_alu`

## Requirements
- R1: Code 3'b000 drives alu_out to all zeros and c_out to 0, whatever the operands.
- R2: Code 3'b001 drives {c_out, alu_out} to acc + 1. An acc of 8'hFF gives alu_out 8'h00 with c_out 1.
- R3: Code 3'b010 drives {c_out, alu_out} to the 9-bit unsigned sum acc + data. c_out is 1 exactly when the sum exceeds 255, and alu_out holds the low 8 bits.
- R4: Code 3'b011 drives alu_out to data unchanged.
- R5: Code 3'b100 drives alu_out to the bitwise ones' complement of acc.
- R6: Codes 3'b101, 3'b110 and 3'b111 drive alu_out to the bitwise AND, OR and XOR of acc and data. Each result bit is correct for all four operand bit pairs 00, 01, 10 and 11.
- R7: For codes 3'b000, 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111, c_out is 0.
- R8: The outputs follow any change of acc, data or op_sel without waiting for a clock edge.
- R9: The data operand has no effect on codes 3'b000, 3'b001 and 3'b100. The acc operand has no effect on code 3'b011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc | input | 8 | Accumulator operand |
| data_in | input | 8 | Second operand |
| op_sel | input | 3 | Operation code |
| alu_out | output | 8 | Result word |
| c_out | output | 1 | Carry, bit 8 of the combined result |

## Verification
The bench targets the carry boundary from both sides. It increments 8'hFF and adds 8'h80 + 8'h80, where a design that lost the ninth bit would show a zero result with no carry. It also runs 8'hFF + 8'h00 and 8'h7F + 8'h80, where a wrongly placed carry would fire falsely. The logic codes use operand pairs that hold every bit pairing, so a swapped OR and XOR, or an inverted bit, shows up in a single word. Operands that an operation should ignore are changed while the code is held, so a design that routes the wrong operand, or leaks a stale carry into a non-arithmetic code, changes its output and is caught.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR  = 3'b000,
        OP_INC    = 3'b001,
        OP_ADD    = 3'b010,
        OP_PASS   = 3'b011,
        OP_INVERT = 3'b100,
        OP_AND    = 3'b101,
        OP_OR     = 3'b110,
        OP_XOR    = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/accu_alu_arith.sv
module accu_alu_arith #(
    parameter int W          = 8,
    parameter bit RIPPLE_ADD = 1'b0
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         inc_mode,
    output logic [W:0]   sum_d
);
    logic [W-1:0] addend_d;

    always_comb begin
        addend_d = inc_mode ? W'(1) : opb;
    end

    generate
        if (RIPPLE_ADD) begin : g_ripple
            always_comb begin
                logic cy;
                cy = 1'b0;
                for (int i = 0; i < W; i++) begin
                    sum_d[i] = opa[i] ^ addend_d[i] ^ cy;
                    cy = (opa[i] & addend_d[i]) | (cy & (opa[i] ^ addend_d[i]));
                end
                sum_d[W] = cy;
            end
        end else begin : g_native
            always_comb begin
                sum_d = {1'b0, opa} + {1'b0, addend_d};
            end
        end
    endgenerate

    always_comb begin
        if (inc_mode && (&opa))
            AST_INC_WRAP: assert (sum_d == {1'b1, {W{1'b0}}}); // R2
    end

endmodule

// File: rtl/accu_alu_logic.sv
module accu_alu_logic
    import accu_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic_fn_e    fn,
    output logic [W-1:0] res_d
);
    always_comb begin
        unique case (fn)
            LG_AND:  res_d = opa & opb;
            LG_OR:   res_d = opa | opb;
            LG_XOR:  res_d = opa ^ opb;
            LG_NOT:  res_d = ~opa;
            default: res_d = 'x;
        endcase
    end

    always_comb begin
        if (fn == LG_NOT)
            AST_INVERT_DISJOINT: assert ((res_d & opa) == '0 && (res_d | opa) == '1); // R5
    end

endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_alu_pkg::*;
#(
    parameter int W          = 8,
    parameter bit RIPPLE_ADD = 1'b0
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] data_in,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] alu_out,
    output logic         c_out
);
    localparam int RW = W + 1;

    typedef struct packed {
        logic         carry;
        logic [W-1:0] word;
    } alu_res_t;

    alu_op_e   op_d;
    logic [W:0] arith_d;
    logic [W-1:0] logic_d;
    logic_fn_e fn_d;
    alu_res_t  res_d;

    always_comb begin
        op_d = alu_op_e'(op_sel);
        unique case (op_d)
            OP_AND:  fn_d = LG_AND;
            OP_OR:   fn_d = LG_OR;
            OP_XOR:  fn_d = LG_XOR;
            default: fn_d = LG_NOT;
        endcase
    end

    accu_alu_arith #(.W(W), .RIPPLE_ADD(RIPPLE_ADD)) u_arith (
        .opa      (acc),
        .opb      (data_in),
        .inc_mode (op_d == OP_INC),
        .sum_d    (arith_d)
    );

    accu_alu_logic #(.W(W)) u_logic (
        .opa   (acc),
        .opb   (data_in),
        .fn    (fn_d),
        .res_d (logic_d)
    );

    always_comb begin
        unique case (op_d)
            OP_CLEAR:                 res_d = '0;
            OP_INC, OP_ADD:           res_d = alu_res_t'(arith_d);
            OP_PASS:                  res_d = '{carry: 1'b0, word: data_in};
            OP_INVERT, OP_AND,
            OP_OR, OP_XOR:            res_d = '{carry: 1'b0, word: logic_d};
            default:                  res_d = 'x;
        endcase
    end

    assign {c_out, alu_out} = RW'(res_d);

    always_comb begin
        if (op_d == OP_CLEAR)
            AST_CLEAR_ZERO: assert ({c_out, alu_out} == '0); // R1
        if (op_d == OP_ADD)
            AST_ADD_CARRY: assert (c_out == (({1'b0, acc} + {1'b0, data_in}) > RW'((1 << W) - 1))); // R3
        if (op_d == OP_PASS)
            AST_PASS_DATA: assert (alu_out == data_in); // R4
        if (op_d != OP_INC && op_d != OP_ADD)
            AST_NO_LOGIC_CARRY: assert (!c_out); // R7
    end

endmodule

// File: tb/accu_alu_tb.sv
module accu_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc = '0;
    logic [7:0] data_in = '0;
    logic [2:0] op_sel = '0;
    logic [7:0] alu_out;
    logic       c_out;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    accu_alu u_dut (
        .acc     (acc),
        .data_in (data_in),
        .op_sel  (op_sel),
        .alu_out (alu_out),
        .c_out   (c_out)
    );

    function automatic logic [8:0] model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        case (op)
            3'b000: return 9'h000;
            3'b001: return {1'b0, a} + 9'd1;
            3'b010: return {1'b0, a} + {1'b0, d};
            3'b011: return {1'b0, d};
            3'b100: return {1'b0, ~a};
            3'b101: return {1'b0, a & d};
            3'b110: return {1'b0, a | d};
            default: return {1'b0, a ^ d};
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        n_run++;
        if ({c_out, alu_out} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b acc=%h data=%h: got %h expected %h",
                     req, op_sel, acc, data_in, {c_out, alu_out}, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        op_sel = op; acc = a; data_in = d;
        #1;
    endtask

    task automatic run(input string req, input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        apply(op, a, d);
        check(req, model(op, a, d));
    endtask

    task automatic t_clear();
        run("R1", 3'b000, 8'hFF, 8'hFF);
        run("R1", 3'b000, 8'h5A, 8'hA5);
    endtask

    task automatic t_increment();
        run("R2", 3'b001, 8'h00, 8'h00);
        run("R2", 3'b001, 8'h7F, 8'h11);
        run("R2", 3'b001, 8'hFE, 8'h00);
        apply(3'b001, 8'hFF, 8'h00);
        check("R2", 9'h100);
    endtask

    task automatic t_add();
        apply(3'b010, 8'h80, 8'h80);
        check("R3", 9'h100);
        apply(3'b010, 8'hFF, 8'h00);
        check("R3", 9'h0FF);
        apply(3'b010, 8'h7F, 8'h80);
        check("R3", 9'h0FF);
        apply(3'b010, 8'hFF, 8'hFF);
        check("R3", 9'h1FE);
        run("R3", 3'b010, 8'h12, 8'h34);
    endtask

    task automatic t_pass_invert();
        run("R4", 3'b011, 8'h00, 8'hC3);
        run("R4", 3'b011, 8'hFF, 8'h00);
        apply(3'b100, 8'hA5, 8'h00);
        check("R5", 9'h05A);
        run("R5", 3'b100, 8'h00, 8'hFF);
    endtask

    task automatic t_logic();
        apply(3'b101, 8'hCC, 8'hAA); check("R6 and", 9'h088);
        apply(3'b110, 8'hCC, 8'hAA); check("R6 or", 9'h0EE);
        apply(3'b111, 8'hCC, 8'hAA); check("R6 xor", 9'h066);
        apply(3'b101, 8'hF0, 8'h3C); check("R6 and", 9'h030);
        apply(3'b110, 8'hF0, 8'h3C); check("R6 or", 9'h0FC);
        apply(3'b111, 8'hF0, 8'h3C); check("R6 xor", 9'h0CC);
    endtask

    task automatic t_no_carry();
        for (int op = 0; op < 8; op++) begin
            if (op != 1 && op != 2) begin
                apply(3'(op), 8'hFF, 8'hFF);
                check("R7", model(3'(op), 8'hFF, 8'hFF));
            end
        end
    endtask

    task automatic t_comb_follow();
        @(negedge clk);
        op_sel = 3'b010; acc = 8'h01; data_in = 8'h01;
        #1 check("R8", 9'h002);
        acc = 8'hF0;
        #1 check("R8", 9'h0F1);
        op_sel = 3'b111;
        #1 check("R8", 9'h0F1);
    endtask

    task automatic t_ignored();
        apply(3'b001, 8'h41, 8'h00); check("R9 inc", 9'h042);
        data_in = 8'hFF; #1 check("R9 inc", 9'h042);
        apply(3'b100, 8'h0F, 8'h00); check("R9 inv", 9'h0F0);
        data_in = 8'h77; #1 check("R9 inv", 9'h0F0);
        apply(3'b000, 8'h33, 8'h00); check("R9 clr", 9'h000);
        data_in = 8'hEE; #1 check("R9 clr", 9'h000);
        apply(3'b011, 8'h00, 8'h5C); check("R9 pass", 9'h05C);
        acc = 8'hFF; #1 check("R9 pass", 9'h05C);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 idle", 9'h000);
        t_clear();
        t_increment();
        t_add();
        t_pass_invert();
        t_logic();
        t_no_carry();
        t_comb_follow();
        t_ignored();
        finish_run();
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule